// File: doc/BRIEF.md
# I2C Multi-Master Bus Monitor

This block sits beside a local I2C master and watches the two open-drain lines, SCL and SDA. From them it tracks the Start and Stop conditions other masters put on the bus. It keeps a Start status bit and a Stop status bit. From those two bits it tells the local master whether the bus can be claimed. When a Stop ends a busy period and the interrupt is enabled, it gives a one-cycle pulse.

While the local master is taking part in a transfer, its sequencer reports the current phase on a 3-bit code, together with the SDA level it is driving. On each rising edge of SCL in a checked phase, the monitor compares that level with the line. If the master has released SDA but the line reads low, another master has won arbitration. The monitor then sets a sticky collision flag and gives a one-cycle collision pulse. Driving the lines and retrying after a loss are left to the surrounding master.

Both lines pass through a synchronizer of `SYNC_STAGES` flops (default 2) before any decision is made.

Top module: `i2c_bus_monitor`

## Requirements
- R1: While `rstN` is low or `enable` is low, `startSeen` and `stopSeen` are both 0, and no Start or Stop is recorded.
- R2: A Start, meaning SDA falling while SCL is high, sets `startSeen` and clears `stopSeen`. With the default synchronizer depth, the status changes at the third rising clock edge after the line change.
- R3: A Stop, meaning SDA rising while SCL is high, sets `stopSeen` and clears `startSeen`. An SDA change while SCL is low changes neither bit.
- R4: `busFree` is 1 when `stopSeen` is set or when both status bits are clear. It is 0 while `startSeen` is set.
- R5: `stopIrq` is a one-cycle pulse, given only when a Stop is detected while `startSeen` is set and `intEnable` is 1. A Stop arriving with `stopSeen` already set, or with `intEnable` low, gives no pulse.
- R6: A collision is detected on a synchronized SCL rising edge when all of the following hold: `enable` is 1, `masterPhase` is 1 to 5, `sdaExpect` is 1, and the synchronized SDA reads 0. The phase codes are 1 address, 2 data, 3 start, 4 repeated start and 5 acknowledge. Code 0 (idle), codes 6 and 7, `sdaExpect` = 0, or SDA read high never give a collision.
- R7: `collFlag` stays set until a one-cycle `collClear`. A collision detected in the same cycle as `collClear` keeps the flag set.
- R8: `collIrq` is a one-cycle pulse in the cycle `collFlag` rises. A collision detected while the flag is already set gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Monitor enable; low clears Start and Stop status |
| intEnable | input | 1 | Enables the Stop interrupt pulse |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| masterPhase | input | 3 | Local master phase code (0 idle, 1-5 checked phases) |
| sdaExpect | input | 1 | SDA level the local master intends (1 = released) |
| collClear | input | 1 | One-cycle clear of the collision flag |
| startSeen | output | 1 | Start status bit |
| stopSeen | output | 1 | Stop status bit |
| busFree | output | 1 | Bus may be claimed |
| stopIrq | output | 1 | One-cycle pulse when a Stop ends a busy period |
| collFlag | output | 1 | Sticky bus-collision flag |
| collIrq | output | 1 | One-cycle pulse when the collision flag rises |

## Verification
A wrong status bit shows at once on `busFree` and on the status pair. It also shows one Stop later, as a missing or extra `stopIrq` pulse. A collision check running in the wrong phase or on the wrong edge shows on `collFlag` three clock edges after the SCL change that caused it. Errors in the pulse logic show as a difference between the number of pulses counted at the ports and the number of busy periods or flag rises the stimulus produced.

// File: rtl/i2c_bus_monitor_pkg.sv
package i2c_bus_monitor_pkg;

  localparam logic [2:0] PHASE_IDLE   = 3'd0;
  localparam logic [2:0] PHASE_ADDR   = 3'd1;
  localparam logic [2:0] PHASE_DATA   = 3'd2;
  localparam logic [2:0] PHASE_START  = 3'd3;
  localparam logic [2:0] PHASE_RSTART = 3'd4;
  localparam logic [2:0] PHASE_ACK    = 3'd5;

  // events seen on the synchronized lines
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sdaLevel;
  } lineEvents_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStatus;
    logic setStart;
    logic setStop;
    logic setColl;
    logic clrColl;
  } ctlStrobes_t;

  function automatic logic phaseChecked(input logic [2:0] ph);
    return (ph >= PHASE_ADDR) && (ph <= PHASE_ACK);
  endfunction

endpackage

// File: rtl/i2c_bus_monitor_datapath.sv
module i2c_bus_monitor_datapath
  import i2c_bus_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  ctlStrobes_t strobes,
  output lineEvents_t events,
  output logic        startSeen,
  output logic        stopSeen,
  output logic        collFlag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclSync, sdaSync;
  logic sclQ, sdaQ;
  logic sclS, sdaS;

  // lines idle high, so reset to 1 to avoid false edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
      sclQ <= sclSync[LAST];
      sdaQ <= sdaSync[LAST];
    end
  end

  assign sclS = sclSync[LAST];
  assign sdaS = sdaSync[LAST];

  always_comb begin
    events.startDet = sclS & sclQ & sdaQ & ~sdaS;
    events.stopDet  = sclS & sclQ & ~sdaQ & sdaS;
    events.sclRise  = sclS & ~sclQ;
    events.sdaLevel = sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (strobes.clrStatus) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (strobes.setStart) begin
      startSeen <= 1'b1;
      stopSeen  <= 1'b0;
    end else if (strobes.setStop) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                collFlag <= 1'b0;
    else if (strobes.setColl) collFlag <= 1'b1;
    else if (strobes.clrColl) collFlag <= 1'b0;
  end

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen)); // R2
  AST_START_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startSeen) |-> $past(events.startDet)); // R2
  AST_STOP_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopSeen) |-> $past(events.stopDet)); // R3

endmodule

// File: rtl/i2c_bus_monitor_control.sv
module i2c_bus_monitor_control
  import i2c_bus_monitor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        intEnable,
  input  logic [2:0]  masterPhase,
  input  logic        sdaExpect,
  input  logic        collClear,
  input  lineEvents_t events,
  input  logic        startSeen,
  input  logic        collFlag,
  output ctlStrobes_t strobes,
  output logic        stopIrq,
  output logic        collIrq
);

  logic checkNow;

  always_comb begin
    checkNow          = enable & phaseChecked(masterPhase) & events.sclRise;
    strobes.clrStatus = ~enable;
    strobes.setStart  = enable & events.startDet;
    strobes.setStop   = enable & events.stopDet;
    strobes.setColl   = checkNow & sdaExpect & ~events.sdaLevel;
    strobes.clrColl   = collClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopIrq <= 1'b0;
      collIrq <= 1'b0;
    end else begin
      stopIrq <= strobes.setStop & startSeen & intEnable;
      collIrq <= strobes.setColl & ~collFlag;
    end
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !startSeen); // R1
  AST_STOPIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |-> $past(intEnable) && $past(startSeen)); // R5
  AST_COLL_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collFlag) |-> $past(phaseChecked(masterPhase)) && $past(sdaExpect)); // R6
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    collFlag && !collClear |=> collFlag); // R7
  AST_COLLIRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    collIrq |=> !collIrq); // R8
  AST_STOPIRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |=> !stopIrq); // R5

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_bus_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       intEnable,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] masterPhase,
  input  logic       sdaExpect,
  input  logic       collClear,
  output logic       startSeen,
  output logic       stopSeen,
  output logic       busFree,
  output logic       stopIrq,
  output logic       collFlag,
  output logic       collIrq
);

  ctlStrobes_t strobes;
  lineEvents_t events;

  i2c_bus_monitor_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDatapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobes(strobes), .events(events),
    .startSeen(startSeen), .stopSeen(stopSeen), .collFlag(collFlag)
  );

  i2c_bus_monitor_control uControl (
    .clk(clk), .rstN(rstN), .enable(enable), .intEnable(intEnable),
    .masterPhase(masterPhase), .sdaExpect(sdaExpect), .collClear(collClear),
    .events(events), .startSeen(startSeen), .collFlag(collFlag),
    .strobes(strobes), .stopIrq(stopIrq), .collIrq(collIrq)
  );

  assign busFree = stopSeen | ~(startSeen | stopSeen);

  AST_BUSY_WHILE_STARTED: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |-> !busFree); // R4

endmodule

// File: tb/sim_i2c_bus_monitor.sv
module sim_i2c_bus_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, intEnable = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic [2:0] masterPhase = 3'd0;
  logic sdaExpect = 1'b0, collClear = 1'b0;
  logic startSeen, stopSeen, busFree, stopIrq, collFlag, collIrq;

  always #4 clk = ~clk;

  i2c_bus_monitor u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .intEnable(intEnable),
    .sclIn(sclIn), .sdaIn(sdaIn), .masterPhase(masterPhase),
    .sdaExpect(sdaExpect), .collClear(collClear),
    .startSeen(startSeen), .stopSeen(stopSeen), .busFree(busFree),
    .stopIrq(stopIrq), .collFlag(collFlag), .collIrq(collIrq)
  );

  typedef struct {
    logic   start, stop, free, coll;
    int     sIrq, cIrq;
    string  req;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;
  int vectors = 0, fails = 0;
  int stopIrqCnt = 0, collIrqCnt = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (stopIrq) stopIrqCnt++;
    if (collIrq) collIrqCnt++;
  end

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        logic [3:0] act, exv;
        e = expQ.pop_front();
        vectors++;
        act = {startSeen, stopSeen, busFree, collFlag};
        exv = {e.start, e.stop, e.free, e.coll};
        if (act !== exv || stopIrqCnt != e.sIrq || collIrqCnt != e.cIrq) begin
          fails++;
          $display("FAIL %s: start/stop/free/coll=%b irqs=%0d/%0d expected %b irqs=%0d/%0d",
                   e.req, act, stopIrqCnt, collIrqCnt, exv, e.sIrq, e.cIrq);
        end
      end
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic scl, input logic sda);
    @(negedge clk);
    sclIn = scl;
    sdaIn = sda;
    waitCycles(4);
  endtask

  task automatic expectState(input logic st, input logic sp, input logic fr,
                             input logic co, input int si, input int ci,
                             input string req);
    expItem_t e;
    e.start = st; e.stop = sp; e.free = fr; e.coll = co;
    e.sIrq = si; e.cIrq = ci; e.req = req;
    expQ.push_back(e);
    -> sampleEv;
    #1;
  endtask

  // raise and lower SCL with SDA held, for the arbitration check
  task automatic clockBit(input logic [2:0] ph, input logic expv, input logic sda);
    @(negedge clk);
    masterPhase = ph;
    sdaExpect = expv;
    drive(1'b0, sda);
    drive(1'b1, sda);
  endtask

  initial begin
    waitCycles(3);
    expectState(0, 0, 1, 0, 0, 0, "R1 reset");
    rstN = 1'b1;
    enable = 1'b1;
    waitCycles(2);

    drive(1'b1, 1'b0);                       // start
    expectState(1, 0, 0, 0, 0, 0, "R2 start");
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);                       // SDA change while SCL low
    drive(1'b1, 1'b1);
    expectState(1, 0, 0, 0, 0, 0, "R3 sda with scl low");

    intEnable = 1'b1;
    drive(1'b0, 1'b1); drive(1'b0, 1'b0); drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);                       // stop
    expectState(0, 1, 1, 0, 1, 0, "R3 R5 stop with irq");

    drive(1'b0, 1'b1); drive(1'b0, 1'b0); drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);                       // stop again, no busy period
    expectState(0, 1, 1, 0, 1, 0, "R5 repeated stop");

    intEnable = 1'b0;
    drive(1'b1, 1'b0);
    expectState(1, 0, 0, 0, 1, 0, "R4 busy after start");
    drive(1'b1, 1'b1);
    expectState(0, 1, 1, 0, 1, 0, "R5 stop irq disabled");

    drive(1'b1, 1'b0);
    @(negedge clk) enable = 1'b0;
    waitCycles(3);
    expectState(0, 0, 1, 0, 1, 0, "R1 disable clears");
    @(negedge clk) enable = 1'b1;
    drive(1'b0, 1'b0);

    clockBit(3'd0, 1'b1, 1'b0);
    expectState(0, 0, 1, 0, 1, 0, "R6 idle phase");
    clockBit(3'd6, 1'b1, 1'b0);
    expectState(0, 0, 1, 0, 1, 0, "R6 phase 6");
    clockBit(3'd1, 1'b0, 1'b0);
    expectState(0, 0, 1, 0, 1, 0, "R6 expect low");
    clockBit(3'd1, 1'b1, 1'b0);
    expectState(0, 0, 1, 1, 1, 1, "R6 R8 address collision");
    clockBit(3'd2, 1'b1, 1'b0);
    expectState(0, 0, 1, 1, 1, 1, "R8 no second pulse");

    @(negedge clk) collClear = 1'b1;
    @(negedge clk) collClear = 1'b0;
    waitCycles(2);
    expectState(0, 0, 1, 0, 1, 1, "R7 clear");

    clockBit(3'd5, 1'b1, 1'b1);
    expectState(0, 0, 1, 0, 1, 1, "R6 sda read high");
    clockBit(3'd5, 1'b1, 1'b0);
    expectState(0, 0, 1, 1, 1, 2, "R6 ack collision");

    // collision and clear in the same cycle: set wins (R7)
    drive(1'b0, 1'b0);
    masterPhase = 3'd3;
    sdaExpect = 1'b1;
    @(negedge clk) sclIn = 1'b1;
    @(negedge clk);
    @(negedge clk) collClear = 1'b1;
    @(negedge clk) collClear = 1'b0;
    waitCycles(3);
    expectState(0, 0, 1, 1, 1, 2, "R7 set beats clear");

    waitCycles(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    waitCycles(200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule